// File: doc/BRIEF.md
# ATA Programmed-I/O Cycle Sequencer

This block carries out a single programmed-I/O register or data cycle on an ATA drive bus each time the host CPU accesses the drive address window. It drives the two chip selects, the three device address lines, the read and write strobes and the 16-bit data bus, and it samples the drive's ready line. While the drive cycle is in progress, the CPU-side access is held in a wait state. The block releases that wait state with read data, or with a write acknowledge, once the address hold time has elapsed.

Each drive cycle has four phases. Each phase is timed by a reload value that software supplies for the selected PIO mode: address setup, strobe width, address hold and recovery. One counter value covers each pair of related minimum timings on the drive bus, so software loads the larger of the pair. Write data is put on the bus from the last cycle of the strobe width onward, rather than being timed by a separate setup counter. The ready line is checked before the strobe is released, and a drive that is not ready stretches the strobe for as long as it needs.

Top module: `ata_pio_seq`

## Requirements
- R1: When `cpu_req` is high and `cpu_ack` is low, `cpu_wait` is high in that same cycle. `cpu_ack` is a one-cycle pulse in the last cycle of the hold phase, and it is the only time `cpu_wait` drops while a request is held.
- R2: From the first setup cycle to the last hold cycle, `ata_cs_n` is `2'b10` when `cpu_addr[3]` is 0 and `2'b01` when it is 1. During the same span, `ata_da` equals `cpu_addr[2:0]` and does not change. Outside a cycle, `ata_cs_n` is `2'b11`.
- R3: A request seen on a clock edge while idle starts the setup phase in the next cycle. Setup lasts eff(`cfg_setup`) cycles with both strobes high, where eff(v) is v, or 1 when v is 0.
- R4: The strobe then goes low: `ata_dior_n` for reads (`cpu_we`=0) and `ata_diow_n` for writes. It stays low for at least eff(`cfg_strobe`) cycles.
- R5: The strobe is released only after a clock edge where the strobe-width count has run out and `ata_iordy` is 1. Each earlier edge with `ata_iordy` at 0 adds one strobe cycle.
- R6: After the strobe rises, the hold phase keeps the chip select and address valid for eff(`cfg_hold`) cycles.
- R7: In a write cycle, `ata_dd_oe` is high and `ata_dd_out` carries the write data from the last cycle of the base strobe width to the end of the hold phase. In a read cycle, `ata_dd_oe` is never high.
- R8: On the edge that ends the strobe of a read cycle, `ata_dd_in` is captured. That value is on `cpu_rdata` during the `cpu_ack` cycle.
- R9: After the hold phase, the select lines are idle for eff(`cfg_recover`) recovery cycles plus one idle cycle before a new request can start. A request made during that time is held in the wait state.
- R10: A configuration value of 0 gives a phase length of exactly one cycle.
- R11: All four timing values are sampled on the edge that starts a cycle. Changing them later in the cycle has no effect on that cycle.
- R12: During reset, both strobes are high, `ata_cs_n` is `2'b11`, and `ata_dd_oe`, `cpu_ack` and `cpu_wait` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | CPU access to the drive window, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Bit 3 selects the chip select; bits 2:0 are the device address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ack` |
| cpu_wait | output | 1 | Wait state toward the CPU |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cfg_setup | input | 8 | Address-setup phase length |
| cfg_strobe | input | 8 | Strobe-width phase length |
| cfg_hold | input | 8 | Address-hold phase length |
| cfg_recover | input | 8 | Recovery phase length |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_da | output | 3 | Device address |
| ata_dior_n | output | 1 | Active-low read strobe |
| ata_diow_n | output | 1 | Active-low write strobe |
| ata_dd_out | output | 16 | Data bus output value |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_in | input | 16 | Data bus input value |
| ata_iordy | input | 1 | Drive ready |

## Verification
The bench aims at these corner cases:
- **Ready-line stalls of several lengths.** A design that ignored the ready line, or sampled it one cycle early, would release the strobe too soon.
- **Read data that is valid only in the final strobe cycle.** A capture one edge off would return the inverted word the bench drives at all other times.
- **Zero configuration values, and values rewritten just after a cycle starts.** A design that underflowed on zero, or read the live registers mid-cycle, would produce phases of the wrong length.
- **Back-to-back requests.** A design that skipped recovery would assert a chip select while the wait state should still be holding the CPU.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4
  } pio_phase_e;

  // A programmed length of zero means one clock.
  function automatic logic [7:0] phase_len(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction

  // The timer counts down to zero, so it is loaded with length minus one.
  function automatic logic [7:0] phase_reload(input logic [7:0] v);
    return phase_len(v) - 8'd1;
  endfunction

endpackage

// File: rtl/pio_phase_timer.sv
module pio_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count_q <= '0;
    else if (load)            count_q <= load_val;
    else if (count_q != '0)   count_q <= count_q - 1'b1;
  end

  assign expired = (count_q == '0);

  // Once the count has run out, it stays at zero until the next load.
  p_timer_parks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          we_in,
  input  logic          sel_in,
  input  logic [AW-1:0] da_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          capture,
  input  logic [DW-1:0] dd_in,
  output logic          we_q,
  output logic          sel_q,
  output logic [AW-1:0] da_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      sel_q   <= 1'b0;
      da_q    <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= we_in;
      sel_q   <= sel_in;
      da_q    <= da_in;
      wdata_q <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dd_in;
  end

  p_capture_reads_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (rdata_q == $past(dd_in)));
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [3:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_wait,
  output logic          cpu_ack,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  input  logic [CW-1:0] cfg_recover,
  output logic [1:0]    ata_cs_n,
  output logic [2:0]    ata_da,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  output logic [DW-1:0] ata_dd_out,
  output logic          ata_dd_oe,
  input  logic [DW-1:0] ata_dd_in,
  input  logic          ata_iordy
);
  localparam int AW = 3;

  pio_phase_e    phase_q, phase_d;
  logic [CW-1:0] strobe_q, hold_q, recov_q;
  logic          t_load, t_done;
  logic [CW-1:0] t_val;
  logic          we_q, sel_q;

  // Named events, used by the assertions below.
  logic start_evt, setup_end_evt, strobe_end_evt, hold_end_evt, recov_end_evt;
  logic in_cycle, data_win;

  assign start_evt      = (phase_q == PH_IDLE)   && cpu_req;
  assign setup_end_evt  = (phase_q == PH_SETUP)  && t_done;
  assign strobe_end_evt = (phase_q == PH_STROBE) && t_done && ata_iordy;
  assign hold_end_evt   = (phase_q == PH_HOLD)   && t_done;
  assign recov_end_evt  = (phase_q == PH_RECOV)  && t_done;

  always_comb begin
    phase_d = phase_q;
    t_load  = 1'b0;
    t_val   = '0;
    if (start_evt) begin
      phase_d = PH_SETUP;  t_load = 1'b1; t_val = phase_reload(cfg_setup);
    end else if (setup_end_evt) begin
      phase_d = PH_STROBE; t_load = 1'b1; t_val = phase_reload(strobe_q);
    end else if (strobe_end_evt) begin
      phase_d = PH_HOLD;   t_load = 1'b1; t_val = phase_reload(hold_q);
    end else if (hold_end_evt) begin
      phase_d = PH_RECOV;  t_load = 1'b1; t_val = phase_reload(recov_q);
    end else if (recov_end_evt) begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      strobe_q <= '0;
      hold_q   <= '0;
      recov_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (start_evt) begin
        strobe_q <= cfg_strobe;
        hold_q   <= cfg_hold;
        recov_q  <= cfg_recover;
      end
    end
  end

  pio_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  pio_datapath #(.DW(DW), .AW(AW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .we_in    (cpu_we),
    .sel_in   (cpu_addr[3]),
    .da_in    (cpu_addr[AW-1:0]),
    .wdata_in (cpu_wdata),
    .capture  (strobe_end_evt && !we_q),
    .dd_in    (ata_dd_in),
    .we_q     (we_q),
    .sel_q    (sel_q),
    .da_q     (ata_da),
    .wdata_q  (ata_dd_out),
    .rdata_q  (cpu_rdata)
  );

  assign in_cycle   = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
  assign data_win   = ((phase_q == PH_STROBE) && t_done) || (phase_q == PH_HOLD);
  assign ata_cs_n   = in_cycle ? (sel_q ? 2'b01 : 2'b10) : 2'b11;
  assign ata_dior_n = !((phase_q == PH_STROBE) && !we_q);
  assign ata_diow_n = !((phase_q == PH_STROBE) &&  we_q);
  assign ata_dd_oe  = we_q && data_win;
  assign cpu_ack    = hold_end_evt;
  assign cpu_wait   = cpu_req && !cpu_ack;

  // Assertions
  p_release_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ata_dior_n) || $rose(ata_diow_n)) |-> $past(ata_iordy));

  p_select_outlives_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ata_dior_n) || $rose(ata_diow_n)) |-> (ata_cs_n != 2'b11));

  p_address_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ata_cs_n != 2'b11) && ($past(ata_cs_n) != 2'b11)) |-> ($stable(ata_da) && $stable(ata_cs_n)));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ata_dd_oe |-> ata_dior_n);

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));

  p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  p_ack_after_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (ata_dior_n && ata_diow_n && (ata_cs_n != 2'b11)));

  p_recovery_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_ack) |-> (ata_cs_n == 2'b11));
endmodule

// File: tb/ata_pio_seq_tb.sv
`timescale 1ns/1ps
module ata_pio_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0, ata_dd_in = '0;
  logic [7:0]  cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0, cfg_recover = '0;
  logic        ata_iordy = 1'b1;
  logic [15:0] cpu_rdata, ata_dd_out;
  logic        cpu_wait, cpu_ack, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [1:0]  ata_cs_n;
  logic [2:0]  ata_da;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ata_pio_seq dut_i (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int len(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Reference model: the phase boundaries of one cycle are worked out as
  // integer offsets from the start edge and compared on every clock.
  task automatic txn(input bit we, input logic [3:0] a, input logic [15:0] d,
                     input int t1, input int t2, input int t4, input int rc,
                     input int stall, input int lead, input bit chain, input string note);
    int e1, e2, e4, strobe_last, hold_end;
    logic [1:0] exp_cs;
    string ph;
    e1 = len(t1); e2 = len(t2); e4 = len(t4);
    strobe_last = e1 + e2 - 1 + stall;
    hold_end    = strobe_last + 1 + e4;
    exp_cs = a[3] ? 2'b01 : 2'b10;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cfg_setup = 8'(t1); cfg_strobe = 8'(t2); cfg_hold = 8'(t4); cfg_recover = 8'(rc);
    ata_iordy = 1'b1;
    for (int k = 0; k <= lead; k++) begin
      @(negedge clk);
      chk("R9", {note, " wait before start"}, 32'(cpu_wait), 32'd1);
      chk("R9", {note, " select idle before start"}, 32'(ata_cs_n), 32'(2'b11));
      @(posedge clk); #1;
    end
    // R11: scramble the live settings right after the start edge.
    cfg_setup = 8'd9; cfg_strobe = 8'd11; cfg_hold = 8'd7; cfg_recover = 8'd6;
    for (int n = 0; n < hold_end; n++) begin
      ata_iordy = (n >= strobe_last);
      ata_dd_in = (n == strobe_last) ? d : ~d;
      @(negedge clk);
      ph = (n < e1) ? "R3" : (n < e1 + e2) ? "R4" : (n <= strobe_last) ? "R5" : "R6";
      chk("R2", {note, " chip select"}, 32'(ata_cs_n), 32'(exp_cs));
      chk("R2", {note, " device address"}, 32'(ata_da), 32'(a[2:0]));
      chk(ph, {note, " read strobe"}, 32'(ata_dior_n), 32'(!(!we && n >= e1 && n <= strobe_last)));
      chk(ph, {note, " write strobe"}, 32'(ata_diow_n), 32'(!(we && n >= e1 && n <= strobe_last)));
      chk("R7", {note, " data enable"}, 32'(ata_dd_oe), 32'(we && n >= e1 + e2 - 1));
      if (we && n >= e1 + e2 - 1) chk("R7", {note, " data value"}, 32'(ata_dd_out), 32'(d));
      chk("R1", {note, " ack"}, 32'(cpu_ack), 32'(n == hold_end - 1));
      chk("R1", {note, " wait"}, 32'(cpu_wait), 32'(n != hold_end - 1));
      if (!we && n == hold_end - 1) chk("R8", {note, " read data"}, 32'(cpu_rdata), 32'(d));
      @(posedge clk); #1;
    end
    ata_iordy = 1'b1;
    if (!chain) begin
      cpu_req = 1'b0;
      for (int n = 0; n < len(rc); n++) begin
        @(negedge clk);
        chk("R9", {note, " recovery select"}, 32'(ata_cs_n), 32'(2'b11));
        chk("R9", {note, " recovery wait"}, 32'(cpu_wait), 32'd0);
        @(posedge clk); #1;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "reset select", 32'(ata_cs_n), 32'(2'b11));
    chk("R12", "reset strobes", 32'({ata_dior_n, ata_diow_n}), 32'(2'b11));
    chk("R12", "reset enable/ack/wait", 32'({ata_dd_oe, cpu_ack, cpu_wait}), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    txn(1'b0, 4'h7, 16'hA5C3, 3, 4, 2, 2, 0, 0, 1'b0, "read plain");
    txn(1'b1, 4'hA, 16'h1234, 2, 3, 3, 1, 0, 0, 1'b0, "write plain");
    txn(1'b0, 4'h1, 16'h0F0F, 1, 2, 1, 1, 3, 0, 1'b0, "read stall3");
    txn(1'b1, 4'hE, 16'hBEEF, 2, 1, 2, 3, 5, 0, 1'b0, "write stall5");
    txn(1'b0, 4'h3, 16'h5AA5, 0, 0, 0, 0, 0, 0, 1'b0, "R10 zeros read");
    txn(1'b1, 4'h8, 16'hC001, 0, 0, 0, 0, 2, 0, 1'b0, "R10 zeros write");
    txn(1'b1, 4'h2, 16'h7E57, 2, 2, 1, 4, 0, 0, 1'b1, "chain first");
    txn(1'b0, 4'hD, 16'h9182, 1, 3, 2, 2, 1, 4, 1'b0, "R9 chain second");
    txn(1'b0, 4'h5, 16'h3C3C, 6, 5, 4, 3, 0, 0, 1'b0, "R11 long");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule